// File: doc/BRIEF.md
# Two-Level Duobinary Couple Interleaver Address Generator

This block produces the permuted couple order that the second constituent encoder of a duobinary turbo encoder consumes. A start pulse and a frame-size code begin a frame. For each output position j from 0 to N-1, the block places a source index on a read port into a buffer that holds the couples in natural order. The buffer answers one cycle later. The block returns the fetched couple, with A and B exchanged whenever the source index is even, and marks it with a valid flag and a last flag.

The index is i = (P0·j + P + 1) mod N. The offset P takes one of four values, chosen by j mod 4. The term P0·j mod N is kept in a running accumulator that adds P0 on each step and subtracts N when the result reaches N. The final sum passes through two conditional subtractions of N. No multiplier or divider is used. The per-size constants come from an internal table.

Top module: `couple_perm_gen`

## Requirements
- R1: size_sel_i codes 0 to 11 select N, P0, P1, P2, P3 in ascending N order: (48,11,24,0,24), (64,7,34,32,2), (212,13,106,108,2), (220,23,112,4,116), (228,17,116,72,188), (424,11,6,8,2), (432,13,0,4,8), (440,13,10,4,2), (752,19,376,224,600), (848,19,2,16,6), (856,19,428,224,652), (864,19,2,16,6). Codes 12 to 15 behave as code 0.
- R2: A start_i sampled high while idle makes rd_en_o high from the next cycle for exactly N consecutive cycles. The cycle with index j presents the address for position j, and rd_en_o is low afterwards.
- R3: rd_addr_o for position j equals (P0·j + P + 1) mod N. P is 0 when j mod 4 = 0, N/2+P1 when it is 1, P2 when it is 2, and N/2+P3 when it is 3.
- R4: The least significant bit of rd_addr_o is always the opposite of the least significant bit of j.
- R5: Over one frame, the addresses issued cover every index 0 to N-1 exactly once.
- R6: One cycle after each cycle with rd_en_o high, valid_o is high and cpl_o carries rd_data_i (bit 1 = A, bit 0 = B). A and B are exchanged when the source index was even and passed straight through when it was odd.
- R7: last_o is high together with valid_o for the couple of position N-1 only.
- R8: start_i and size_sel_i are ignored while a frame is in progress.
- R9: During and after reset, rd_en_o, valid_o and last_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start pulse |
| size_sel_i | input | 4 | Frame-size code |
| rd_data_i | input | 2 | Couple read from the buffer, {A,B}, one cycle after the address |
| rd_addr_o | output | 10 | Source couple index |
| rd_en_o | output | 1 | Read request |
| cpl_o | output | 2 | Couple after the intra-couple exchange, {A,B} |
| valid_o | output | 1 | cpl_o holds a couple |
| last_o | output | 1 | Final couple of the frame |

## Verification
The address for position j is due in the (j+1)-th cycle after the edge that samples start_i. The couple for that position follows one cycle later, together with valid_o and last_o. The bench drives start_i on a falling edge. From the next falling edge onward it checks the address for position j and the output couple for position j-1 at each falling edge. After a frame it checks one more edge for the last couple and a further edge for idle outputs. Expected indices are computed with a true multiply and modulo. Expected couples come from the bench's own buffer model, which returns a hash of the address one cycle after the read.

// File: rtl/perm_pkg.sv
package perm_pkg;
  localparam int MAX_N  = 864;
  localparam int IDX_W  = $clog2(MAX_N);
  localparam int OFF_W  = IDX_W + 1;
  localparam int SUM_W  = IDX_W + 2;
  localparam int SEL_W  = 4;

  typedef struct packed {
    logic [IDX_W-1:0] n;
    logic [IDX_W-1:0] p0;
    logic [IDX_W-1:0] p1;
    logic [IDX_W-1:0] p2;
    logic [IDX_W-1:0] p3;
  } perm_cfg_t;

  function automatic perm_cfg_t mk_cfg(int n, int p0, int p1, int p2, int p3);
    perm_cfg_t c;
    c.n  = IDX_W'(n);
    c.p0 = IDX_W'(p0);
    c.p1 = IDX_W'(p1);
    c.p2 = IDX_W'(p2);
    c.p3 = IDX_W'(p3);
    return c;
  endfunction
endpackage

// File: rtl/perm_param_rom.sv
module perm_param_rom
  import perm_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output perm_cfg_t        cfg_o
);
  always_comb begin
    unique case (sel_i)
      4'd1:    cfg_o = mk_cfg(64,  7,  34,  32,  2);
      4'd2:    cfg_o = mk_cfg(212, 13, 106, 108, 2);
      4'd3:    cfg_o = mk_cfg(220, 23, 112, 4,   116);
      4'd4:    cfg_o = mk_cfg(228, 17, 116, 72,  188);
      4'd5:    cfg_o = mk_cfg(424, 11, 6,   8,   2);
      4'd6:    cfg_o = mk_cfg(432, 13, 0,   4,   8);
      4'd7:    cfg_o = mk_cfg(440, 13, 10,  4,   2);
      4'd8:    cfg_o = mk_cfg(752, 19, 376, 224, 600);
      4'd9:    cfg_o = mk_cfg(848, 19, 2,   16,  6);
      4'd10:   cfg_o = mk_cfg(856, 19, 428, 224, 652);
      4'd11:   cfg_o = mk_cfg(864, 19, 2,   16,  6);
      default: cfg_o = mk_cfg(48,  11, 24,  0,   24);
    endcase
  end
endmodule

// File: rtl/perm_index_calc.sv
module perm_index_calc
  import perm_pkg::*;
#(
  parameter int NUM_RED = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  perm_cfg_t        cfg_i,
  output logic [IDX_W-1:0] addr_o,
  output logic             en_o,
  output logic             last_o
);
  logic             active_q;
  logic [IDX_W-1:0] j_q, acc_q, n_q, p0_q;
  logic [OFF_W-1:0] off_q [4];
  logic [OFF_W-1:0] acc_sum;
  logic [IDX_W-1:0] acc_nxt;
  logic [SUM_W-1:0] red [NUM_RED+1];

  // running P0*j mod N
  assign acc_sum = {1'b0, acc_q} + {1'b0, p0_q};
  assign acc_nxt = (acc_sum >= {1'b0, n_q}) ? IDX_W'(acc_sum - {1'b0, n_q})
                                            : acc_sum[IDX_W-1:0];

  assign red[0] = SUM_W'(acc_q) + SUM_W'(off_q[j_q[1:0]]) + SUM_W'(1);
  for (genvar g = 0; g < NUM_RED; g++) begin : g_red
    assign red[g+1] = (red[g] >= SUM_W'(n_q)) ? red[g] - SUM_W'(n_q) : red[g];
  end

  assign addr_o = red[NUM_RED][IDX_W-1:0];
  assign en_o   = active_q;
  assign last_o = active_q && (j_q == n_q - IDX_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      j_q      <= '0;
      acc_q    <= '0;
      n_q      <= IDX_W'(1);
      p0_q     <= '0;
      for (int k = 0; k < 4; k++) off_q[k] <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        j_q      <= '0;
        acc_q    <= '0;
        n_q      <= cfg_i.n;
        p0_q     <= cfg_i.p0;
        off_q[0] <= '0;
        off_q[1] <= OFF_W'(cfg_i.n >> 1) + OFF_W'(cfg_i.p1);
        off_q[2] <= OFF_W'(cfg_i.p2);
        off_q[3] <= OFF_W'(cfg_i.n >> 1) + OFF_W'(cfg_i.p3);
      end
    end else begin
      if (last_o) active_q <= 1'b0;
      j_q   <= j_q + IDX_W'(1);
      acc_q <= acc_nxt;
    end
  end

  assert_addr_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (addr_o < n_q));
  assert_parity_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (addr_o[0] != j_q[0]));
  assert_acc_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (acc_q < n_q));
  assert_j_steps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && !last_o) |=> (en_o && j_q == $past(j_q) + IDX_W'(1)));
  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && start_i) |=> (n_q == $past(n_q) && p0_q == $past(p0_q)));
endmodule

// File: rtl/couple_swap_stage.sv
module couple_swap_stage (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       last_i,
  input  logic       src_lsb_i,
  input  logic [1:0] rd_data_i,
  output logic [1:0] cpl_o,
  output logic       valid_o,
  output logic       last_o
);
  logic valid_q, last_q, swap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      swap_q  <= 1'b0;
    end else begin
      valid_q <= en_i;
      last_q  <= en_i && last_i;
      swap_q  <= en_i && !src_lsb_i;
    end
  end

  assign cpl_o   = swap_q ? {rd_data_i[0], rd_data_i[1]} : rd_data_i;
  assign valid_o = valid_q;
  assign last_o  = last_q;

  assert_valid_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(en_i));
  assert_last_with_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
endmodule

// File: rtl/couple_perm_gen.sv
module couple_perm_gen
  import perm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] size_sel_i,
  input  logic [1:0]       rd_data_i,
  output logic [IDX_W-1:0] rd_addr_o,
  output logic             rd_en_o,
  output logic [1:0]       cpl_o,
  output logic             valid_o,
  output logic             last_o
);
  perm_cfg_t cfg;
  logic      idx_last;

  perm_param_rom u_rom (
    .sel_i (size_sel_i),
    .cfg_o (cfg)
  );

  perm_index_calc #(.NUM_RED(2)) u_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cfg_i   (cfg),
    .addr_o  (rd_addr_o),
    .en_o    (rd_en_o),
    .last_o  (idx_last)
  );

  couple_swap_stage u_swap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rd_en_o),
    .last_i    (idx_last),
    .src_lsb_i (rd_addr_o[0]),
    .rd_data_i (rd_data_i),
    .cpl_o     (cpl_o),
    .valid_o   (valid_o),
    .last_o    (last_o)
  );

  assert_no_valid_in_reset_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !last_o));
endmodule

// File: tb/sim_couple_perm_gen.sv
module sim_couple_perm_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] sel = '0;
  logic [1:0] rd_data = '0;
  logic [9:0] rd_addr;
  logic       rd_en;
  logic [1:0] cpl;
  logic       valid, last;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  couple_perm_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_sel_i(sel),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .rd_en_o(rd_en),
    .cpl_o(cpl), .valid_o(valid), .last_o(last)
  );

  function automatic logic [1:0] hash(logic [9:0] a);
    return {^(a & 10'h2A5), ^(a & 10'h15B)};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= hash(rd_addr);

  function automatic void cfg_of(int code, output int n, output int p0,
                                 output int p1, output int p2, output int p3);
    case (code)
      1:  begin n=64;  p0=7;  p1=34;  p2=32;  p3=2;   end
      2:  begin n=212; p0=13; p1=106; p2=108; p3=2;   end
      3:  begin n=220; p0=23; p1=112; p2=4;   p3=116; end
      4:  begin n=228; p0=17; p1=116; p2=72;  p3=188; end
      5:  begin n=424; p0=11; p1=6;   p2=8;   p3=2;   end
      6:  begin n=432; p0=13; p1=0;   p2=4;   p3=8;   end
      7:  begin n=440; p0=13; p1=10;  p2=4;   p3=2;   end
      8:  begin n=752; p0=19; p1=376; p2=224; p3=600; end
      9:  begin n=848; p0=19; p1=2;   p2=16;  p3=6;   end
      10: begin n=856; p0=19; p1=428; p2=224; p3=652; end
      11: begin n=864; p0=19; p1=2;   p2=16;  p3=6;   end
      default: begin n=48; p0=11; p1=24; p2=0; p3=24; end
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(int code, bit poke);
    int n, p0, p1, p2, p3, prev_src, cnt;
    bit seen [864];
    cfg_of(code, n, p0, p1, p2, p3);
    foreach (seen[k]) seen[k] = 0;
    sel = 4'(code);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev_src = -1;
    for (int j = 0; j < n; j++) begin
      int p, e, x;
      case (j % 4)
        0: p = 0;
        1: p = n/2 + p1;
        2: p = p2;
        default: p = n/2 + p3;
      endcase
      e = (p0 * j + p + 1) % n;
      chk(rd_en === 1'b1, "R2 rd_en", int'(rd_en), 1);
      chk(rd_addr == 10'(e), "R3 addr", int'(rd_addr), e);
      chk(rd_addr[0] != j[0], "R4 parity", int'(rd_addr[0]), int'(!j[0]));
      seen[rd_addr] = 1;
      if (prev_src >= 0) begin
        x = prev_src[0] ? int'(hash(10'(prev_src)))
                        : int'({hash(10'(prev_src))[0], hash(10'(prev_src))[1]});
        chk(valid === 1'b1 && cpl == 2'(x), "R6 couple", int'(cpl), x);
        chk(last === 1'b0, "R7 early last", int'(last), 0);
      end
      prev_src = e;
      if (poke && j == 10) begin
        sel = 4'd11;
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      sel = 4'(code);
    end
    begin
      int x;
      x = prev_src[0] ? int'(hash(10'(prev_src)))
                      : int'({hash(10'(prev_src))[0], hash(10'(prev_src))[1]});
      chk(valid === 1'b1 && cpl == 2'(x), "R6 final couple", int'(cpl), x);
      chk(last === 1'b1, "R7 last", int'(last), 1);
      chk(rd_en === 1'b0, "R2 rd_en end", int'(rd_en), 0);
    end
    cnt = 0;
    for (int k = 0; k < n; k++) if (seen[k]) cnt++;
    chk(cnt == n, poke ? "R5 R8 permutation" : "R5 permutation", cnt, n);
    @(negedge clk);
    chk(valid === 1'b0 && last === 1'b0, "R7 idle after frame", int'(valid), 0);
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_en === 1'b0 && valid === 1'b0 && last === 1'b0, "R9 reset",
        int'({rd_en, valid, last}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_en === 1'b0 && valid === 1'b0, "R9 idle", int'({rd_en, valid}), 0);
    run_frame(0, 1'b1);                       // R8 start during frame
    for (int c = 1; c < 12; c++) run_frame(c, 1'b0);  // R1 every size
    run_frame(13, 1'b0);                      // R1 unused code
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule